// File: doc/BRIEF.md
# Banked Index/Data Register Port for a Hardware Monitor

This block is the register-access front end of a hardware-monitor function. Software sees an eight-byte I/O window. One offset holds a 7-bit index. Another offset is the data port, which reads or writes the register the index selects. Behind the port is a flop register file with fixed reset defaults.

Live sensor readings are not stored in the file. Seven voltage channels, one temperature and three fan counts come in on input ports, and the read path returns them at fixed indexes. A bank field in a control register redirects a small window of indexes to alternate eight-byte pages. The index steps forward by itself on a few chosen registers, so that a block of values can be read or written with repeated data-port accesses. Two control bits let software return the register file to its defaults without a hardware reset.

An upper range of indexes aliases a lower range. A 16-bit vendor identifier is presented one byte at a time, and a bit in the bank register selects which byte.

Top module: `hwm_bank_port`

## Requirements
- R1: After hardware reset the index is 0x00 and every register reads 0x00, except index 0x40 = 0x08, 0x46 = 0x40 and 0x47 = 0x50. Sensor indexes return their inputs as stated in R8, and index 0x4F returns the vendor byte as stated in R10.
- R2: Writing window offset 5 loads the index with bits [6:0] of the written byte. Reading offset 5 returns {0, index}. Reading any offset other than 5 or 6 returns 0xFF.
- R3: The bank number is bits [2:0] of register 0x4E. In a nonzero bank, indexes 0x50 to 0x57 address page (bank-1) when the bank is at most ALT_PAGES (default 2). In a higher bank these indexes read 0x00 and ignore writes. In bank 0 they are ordinary registers.
- R4: In bank 0, a data-port read or write steps the index by one (7-bit wrap, so 0x7F becomes 0x00) when the index before the access is 0x41, 0x43, 0x45, 0x56 or 0x60 to 0x7F. No other access moves the index.
- R5: Indexes 0x60 to 0x7F read and write the register at index AND 0x3F.
- R6: Data-port writes to 0x00 to 0x05, 0x20 to 0x2A, 0x41, 0x42, 0x4F, 0x58 and 0x60 to 0x6A are discarded.
- R7: A data write to 0x40 with bit 7 set reloads the R1 defaults in the register file and clears the alternate pages. The index is left unchanged.
- R8: Index 0x20+n (n = 0 to 6) reads bits [11:4] of voltage channel n. Index 0x27 reads the temperature input. Indexes 0x28 to 0x2A read fan inputs 0 to 2.
- R9: A data write to 0x49 with bit 5 clear leaves 0x49 reading 0x40. A data write to 0x49 with bit 5 set performs the R7 reload.
- R10: Index 0x4F reads bits [15:8] of VENDOR_ID when bit 7 of 0x4E is 1, and bits [7:0] when it is 0.
- R11: Any other index in the register file that is writable keeps the last byte written to it and returns that byte on read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Offset within the I/O window |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe (steps the index where R4 applies) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset and index, combinational |
| volt_in | input | 7*VOLT_W | Voltage channels, channel n at bits [n*VOLT_W +: VOLT_W] |
| temp_in | input | 8 | Temperature reading |
| fan_in | input | 24 | Fan counts, fan n at bits [n*8 +: 8] |

## Verification
Directed sequences cover each of the following:
- the reset defaults;
- every index that steps, and the wrap from 0x7F to 0x00;
- writes to read-only indexes;
- both reload triggers;
- both vendor-byte selections;
- page selection in banks 1, 2 and an unmapped bank.

A long random stream then mixes index loads, data reads, data writes and stray offsets. The stream draws from a pool of indexes weighted toward the boundaries. Because bank-register writes appear in the stream, page redirection and the bank-0 condition for stepping the index are exercised together. The stream also tells apart an index that stepped from one that stayed, and an aliased write from a direct one.

// File: rtl/hwm_pkg.sv
package hwm_pkg;

   localparam int unsigned IDX_W   = 7;
   localparam int unsigned DEPTH   = 1 << IDX_W;
   localparam int unsigned VOLT_CH = 7;
   localparam int unsigned FAN_CH  = 3;

   localparam logic [2:0] PORT_INDEX = 3'd5;
   localparam logic [2:0] PORT_DATA  = 3'd6;

   localparam logic [IDX_W-1:0] IDX_CFG    = 7'h40;
   localparam logic [IDX_W-1:0] IDX_RSTCTL = 7'h49;
   localparam logic [IDX_W-1:0] IDX_BANK   = 7'h4E;
   localparam logic [IDX_W-1:0] IDX_VENDOR = 7'h4F;
   localparam logic [IDX_W-1:0] IDX_TEMP   = 7'h27;

   typedef logic [DEPTH-1:0][7:0] regfile_t;

   function automatic regfile_t reset_image();
      regfile_t r;
      r        = '0;
      r[7'h40] = 8'h08;
      r[7'h46] = 8'h40;
      r[7'h47] = 8'h50;
      return r;
   endfunction

   function automatic logic is_read_only(logic [IDX_W-1:0] i);
      return (i <= 7'h05) || (i >= 7'h20 && i <= 7'h2A) ||
             (i == 7'h41) || (i == 7'h42) || (i == 7'h4F) ||
             (i == 7'h58) || (i >= 7'h60 && i <= 7'h6A);
   endfunction

   function automatic logic steps_index(logic [IDX_W-1:0] i);
      return (i == 7'h41) || (i == 7'h43) || (i == 7'h45) ||
             (i == 7'h56) || (i >= 7'h60);
   endfunction

   function automatic logic [IDX_W-1:0] fold_index(logic [IDX_W-1:0] i);
      return (i >= 7'h60) ? {1'b0, i[5:0]} : i;
   endfunction

   function automatic logic in_page_window(logic [IDX_W-1:0] i);
      return i[6:3] == 4'b1010;
   endfunction

endpackage

// File: rtl/hwm_index_ctl.sv
module hwm_index_ctl
   import hwm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] load_val,
   input  logic             step,
   output logic [IDX_W-1:0] idx
);

   always_ff @(posedge clk) begin
      if (!rst_n)    idx <= '0;
      else if (load) idx <= load_val;
      else if (step) idx <= idx + 1'b1;
   end

   a_r2_index_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> idx == $past(load_val));

   a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> $stable(idx));

endmodule

// File: rtl/hwm_reg_store.sv
module hwm_reg_store
   import hwm_pkg::*;
#(
   parameter int unsigned ALT_PAGES = 2
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              idx,
   input  logic [7:0]                    wdata,
   output regfile_t                      mem,
   output logic [ALT_PAGES-1:0][7:0][7:0] alt,
   output logic [2:0]                    bank
);

   logic [IDX_W-1:0] tgt;
   logic             page_sel, ro_hit, plain_wr, soft_rst, unmapped_page;

   assign bank          = mem[IDX_BANK][2:0];
   assign tgt           = fold_index(idx);
   assign page_sel      = (bank != 3'd0) && in_page_window(idx);
   assign unmapped_page = page_sel && (32'(bank) > ALT_PAGES);
   assign ro_hit        = is_read_only(idx);
   assign plain_wr      = wr_en && !page_sel && !ro_hit;
   assign soft_rst      = plain_wr &&
                          (((tgt == IDX_CFG) && wdata[7]) ||
                           ((tgt == IDX_RSTCTL) && wdata[5]));

   always_ff @(posedge clk) begin
      if (!rst_n)
         mem <= reset_image();
      else if (soft_rst)
         mem <= reset_image();
      else if (plain_wr) begin
         if (tgt == IDX_RSTCTL) mem[tgt] <= 8'h40;
         else                   mem[tgt] <= wdata;
      end
   end

   for (genvar p = 0; p < ALT_PAGES; p++) begin : g_page
      always_ff @(posedge clk) begin
         if (!rst_n || soft_rst)
            alt[p] <= '0;
         else if (wr_en && page_sel && (32'(bank) == p + 1))
            alt[p][idx[2:0]] <= wdata;
      end
   end

   a_r6_ro_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ro_hit && !page_sel) |=> $stable(mem));

   a_r7_init_defaults: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !page_sel && idx == IDX_CFG && wdata[7])
      |=> (mem[7'h40] == 8'h08 && mem[7'h47] == 8'h50 && mem[IDX_BANK] == 8'h00));

   a_r9_ctl_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !page_sel && idx == IDX_RSTCTL && !wdata[5]) |=> mem[IDX_RSTCTL] == 8'h40);

   a_r3_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && unmapped_page) |=> ($stable(mem) && $stable(alt)));

endmodule

// File: rtl/hwm_read_sel.sv
module hwm_read_sel
   import hwm_pkg::*;
#(
   parameter int unsigned ALT_PAGES = 2,
   parameter int unsigned VOLT_W    = 12,
   parameter logic [15:0] VENDOR_ID = 16'h5CA3
)(
   input  logic [IDX_W-1:0]              idx,
   input  regfile_t                      mem,
   input  logic [ALT_PAGES-1:0][7:0][7:0] alt,
   input  logic [2:0]                    bank,
   input  logic [VOLT_CH*VOLT_W-1:0]     volt_in,
   input  logic [7:0]                    temp_in,
   input  logic [FAN_CH*8-1:0]           fan_in,
   output logic [7:0]                    rd_val
);

   logic [7:0] volt_byte [VOLT_CH];
   logic [7:0] fan_byte  [FAN_CH];

   for (genvar c = 0; c < VOLT_CH; c++) begin : g_volt
      logic [3:0] unused_lsb;
      assign volt_byte[c] = volt_in[c*VOLT_W + 4 +: 8];
      assign unused_lsb   = volt_in[c*VOLT_W +: 4];
      if (VOLT_W > 12) begin : g_wide
         logic [VOLT_W-13:0] unused_msb;
         assign unused_msb = volt_in[c*VOLT_W + 12 +: VOLT_W-12];
      end
   end

   for (genvar f = 0; f < FAN_CH; f++) begin : g_fan
      assign fan_byte[f] = fan_in[f*8 +: 8];
   end

   logic [IDX_W-1:0] m;
   assign m = fold_index(idx);

   always_comb begin
      if (bank != 3'd0 && in_page_window(idx)) begin
         rd_val = 8'h00;
         for (int p = 0; p < ALT_PAGES; p++)
            if (32'(bank) == p + 1) rd_val = alt[p][idx[2:0]];
      end
      else if (m >= 7'h20 && m <= 7'h26)
         rd_val = volt_byte[m[2:0]];
      else if (m == IDX_TEMP)
         rd_val = temp_in;
      else if (m >= 7'h28 && m <= 7'h2A)
         rd_val = fan_byte[m[1:0]];
      else if (idx == IDX_VENDOR)
         rd_val = mem[IDX_BANK][7] ? VENDOR_ID[15:8] : VENDOR_ID[7:0];
      else
         rd_val = mem[m];
   end

endmodule

// File: rtl/hwm_bank_port.sv
module hwm_bank_port
   import hwm_pkg::*;
#(
   parameter int unsigned ALT_PAGES = 2,
   parameter int unsigned VOLT_W    = 12,
   parameter logic [15:0] VENDOR_ID = 16'h5CA3
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [2:0]                bus_addr,
   input  logic                      bus_wr,
   input  logic                      bus_rd,
   input  logic [7:0]                bus_wdata,
   output logic [7:0]                bus_rdata,
   input  logic [VOLT_CH*VOLT_W-1:0] volt_in,
   input  logic [7:0]                temp_in,
   input  logic [FAN_CH*8-1:0]       fan_in
);

   if (ALT_PAGES < 1 || ALT_PAGES > 7) begin : g_bad_pages
      $error("ALT_PAGES must lie in 1..7");
   end
   if (VOLT_W < 12) begin : g_bad_volt
      $error("VOLT_W must be at least 12");
   end

   logic [IDX_W-1:0]              idx;
   logic [2:0]                    bank;
   regfile_t                      mem;
   logic [ALT_PAGES-1:0][7:0][7:0] alt;
   logic [7:0]                    rd_val;
   logic                          data_acc, idx_load, idx_step;

   assign data_acc = (bus_rd || bus_wr) && (bus_addr == PORT_DATA);
   assign idx_load = bus_wr && (bus_addr == PORT_INDEX);
   assign idx_step = data_acc && (bank == 3'd0) && steps_index(idx);

   hwm_index_ctl u_index (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (idx_load),
      .load_val (bus_wdata[IDX_W-1:0]),
      .step     (idx_step),
      .idx      (idx)
   );

   hwm_reg_store #(.ALT_PAGES(ALT_PAGES)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (bus_wr && (bus_addr == PORT_DATA)),
      .idx   (idx),
      .wdata (bus_wdata),
      .mem   (mem),
      .alt   (alt),
      .bank  (bank)
   );

   hwm_read_sel #(.ALT_PAGES(ALT_PAGES), .VOLT_W(VOLT_W), .VENDOR_ID(VENDOR_ID)) u_read (
      .idx     (idx),
      .mem     (mem),
      .alt     (alt),
      .bank    (bank),
      .volt_in (volt_in),
      .temp_in (temp_in),
      .fan_in  (fan_in),
      .rd_val  (rd_val)
   );

   always_comb begin
      case (bus_addr)
         PORT_INDEX: bus_rdata = {1'b0, idx};
         PORT_DATA:  bus_rdata = rd_val;
         default:    bus_rdata = 8'hFF;
      endcase
   end

   a_r4_step_at_41: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == PORT_DATA && idx == 7'h41 && bank == 3'd0) |=> idx == 7'h42);

   a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == PORT_DATA && idx == 7'h7F && bank == 3'd0) |=> idx == 7'h00);

   a_r4_no_step_other_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && bank != 3'd0) |=> $stable(idx));

endmodule

// File: tb/hwm_bank_port_bench.sv
module hwm_bank_port_bench;

   localparam int ALT = 2;
   localparam int VEN = 'h5CA3;

   logic        clk = 0;
   logic        rst_n = 0;
   logic [2:0]  bus_addr = 0;
   logic        bus_wr = 0, bus_rd = 0;
   logic [7:0]  bus_wdata = 0;
   logic [7:0]  bus_rdata;
   logic [83:0] volt_in;
   logic [7:0]  temp_in = 8'h1E;
   logic [23:0] fan_in = 24'h9C_5A_37;
   logic [11:0] vch [7];

   always #2 clk = ~clk;

   for (genvar g = 0; g < 7; g++) begin : g_v
      assign volt_in[g*12 +: 12] = vch[g];
   end

   hwm_bank_port u_hwm_bank_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .volt_in(volt_in), .temp_in(temp_in), .fan_in(fan_in));

   int checks = 0, failures = 0;
   bit done = 0;
   int mem [128];
   int alt [ALT][8];
   int idx;

   function automatic void mdl_reset();
      foreach (mem[i]) mem[i] = 0;
      foreach (alt[p, j]) alt[p][j] = 0;
      mem['h40] = 'h08; mem['h46] = 'h40; mem['h47] = 'h50;
   endfunction

   function automatic bit ro(int i);
      return (i <= 'h05) || (i >= 'h20 && i <= 'h2A) || i == 'h41 || i == 'h42 ||
             i == 'h4F || i == 'h58 || (i >= 'h60 && i <= 'h6A);
   endfunction

   function automatic int reg_rd(int i);
      int b = mem['h4E] & 7;
      int m = (i >= 'h60) ? (i & 'h3F) : i;
      if (b != 0 && i >= 'h50 && i <= 'h57) return (b <= ALT) ? alt[b-1][i & 7] : 0;
      if (m >= 'h20 && m <= 'h26) return (vch[m - 'h20] >> 4) & 'hFF;
      if (m == 'h27) return temp_in;
      if (m >= 'h28 && m <= 'h2A) return (fan_in >> ((m - 'h28) * 8)) & 'hFF;
      if (i == 'h4F) return (mem['h4E] & 'h80) ? (VEN >> 8) : (VEN & 'hFF);
      return mem[m];
   endfunction

   function automatic void reg_wr(int i, int v);
      int b = mem['h4E] & 7;
      int m = (i >= 'h60) ? (i & 'h3F) : i;
      if (b != 0 && i >= 'h50 && i <= 'h57) begin
         if (b <= ALT) alt[b-1][i & 7] = v;
         return;
      end
      if (ro(i)) return;
      mem[m] = v;
      if (m == 'h40 && (v & 'h80)) mdl_reset();
      if (m == 'h49) begin
         if (v & 'h20) mdl_reset(); else mem['h49] = 'h40;
      end
   endfunction

   function automatic int port_rd(int a);
      if (a == 5) return idx;
      if (a == 6) return reg_rd(idx);
      return 'hFF;
   endfunction

   task automatic chk(int got, int exp, string tag);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
      end
   endtask

   task automatic op(int a, bit w, bit r, int d, string tag);
      bit inc;
      @(negedge clk);
      bus_addr = a[2:0]; bus_wr = w; bus_rd = r; bus_wdata = d[7:0];
      #1;
      chk(bus_rdata, port_rd(a), tag);
      @(posedge clk);
      inc = (a == 6) && (w || r) && ((mem['h4E] & 7) == 0) &&
            (idx == 'h41 || idx == 'h43 || idx == 'h45 || idx == 'h56 || idx >= 'h60);
      if (w && a == 5) idx = d & 'h7F;
      if (w && a == 6) reg_wr(idx, d & 'hFF);
      if (inc) idx = (idx + 1) & 'h7F;
   endtask

   task automatic seti(int i, string tag); op(5, 1, 0, i, tag); endtask
   task automatic rd6(string tag);         op(6, 0, 1, 0, tag); endtask
   task automatic wr6(int d, string tag);  op(6, 1, 0, d, tag); endtask
   task automatic rdi(string tag);         op(5, 0, 1, 0, tag); endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int pool [16] = '{'h00, 'h10, 'h26, 'h27, 'h2A, 'h40, 'h41, 'h44,
                        'h49, 'h4E, 'h4F, 'h52, 'h56, 'h65, 'h70, 'h7F};
      for (int c = 0; c < 7; c++) vch[c] = 12'(('h3A5 + c * 'h1F3) & 'hFFF);
      mdl_reset(); idx = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;

      // R1 reset state
      rdi("R1 index"); rd6("R1 reg00");
      seti('h40, "R1"); rd6("R1 cfg");
      seti('h46, "R1"); rd6("R1 46"); seti('h47, "R1"); rd6("R1 47");
      // R2 index masking, stray offsets
      seti('hC5, "R2 mask"); rdi("R2 readback");
      op(0, 0, 1, 0, "R2 off0"); op(7, 0, 1, 0, "R2 off7"); op(4, 0, 1, 0, "R2 off4");
      // R11 plain register
      seti('h10, "R11"); wr6('hA5, "R11 wr"); rd6("R11 rd"); rdi("R11 idx"); rd6("R11 rd2");
      // R4 stepping
      seti('h41, "R4"); rd6("R4 41"); rdi("R4 42");
      seti('h43, "R4"); wr6('h12, "R4 43"); rdi("R4 44"); rd6("R4 44 rd"); rdi("R4 nostep");
      seti('h45, "R4"); rd6("R4 45"); rdi("R4 46");
      seti('h56, "R4"); rd6("R4 56"); rdi("R4 57");
      seti('h7F, "R4"); rd6("R4 7f"); rdi("R4 wrap");
      // R5 alias
      seti('h70, "R5"); wr6('h3C, "R5 wr"); rdi("R5 step"); seti('h30, "R5"); rd6("R5 low");
      seti('h2F, "R5"); wr6('h99, "R5"); seti('h6F, "R5"); rd6("R5 high");
      // R6 read-only
      seti('h41, "R6"); wr6('h77, "R6"); seti('h41, "R6"); rd6("R6 41");
      seti('h58, "R6"); wr6('h77, "R6"); rd6("R6 58");
      seti('h03, "R6"); wr6('h77, "R6"); rd6("R6 03");
      seti('h65, "R6"); wr6('h77, "R6"); seti('h25, "R6"); rd6("R6 65");
      seti('h4F, "R6"); wr6('h00, "R6"); rd6("R6 4f");
      // R8 sensors
      for (int i = 'h20; i <= 'h2A; i++) begin seti(i, "R8"); rd6("R8 sensor"); end
      vch[3] = 12'hFF0; temp_in = 8'hC4; seti('h23, "R8"); rd6("R8 v3"); seti('h27, "R8"); rd6("R8 temp");
      // R10 vendor
      seti('h4F, "R10"); rd6("R10 low");
      seti('h4E, "R10"); wr6('h80, "R10"); seti('h4F, "R10"); rd6("R10 high");
      // R3 banks
      seti('h4E, "R3"); wr6('h01, "R3"); seti('h52, "R3"); wr6('h9A, "R3 p1"); rd6("R3 p1 rd");
      seti('h4E, "R3"); wr6('h02, "R3"); seti('h52, "R3"); wr6('h11, "R3 p2"); rd6("R3 p2 rd");
      seti('h4E, "R3"); wr6('h05, "R3"); seti('h52, "R3"); wr6('h44, "R3 unm"); rd6("R3 unm rd");
      seti('h41, "R3"); rd6("R3 R4 bank"); rdi("R3 nostep");
      seti('h4E, "R3"); wr6('h01, "R3"); seti('h52, "R3"); rd6("R3 p1 again");
      seti('h4E, "R3"); wr6('h00, "R3"); seti('h52, "R3"); rd6("R3 bank0");
      // R7 soft init
      seti('h10, "R7"); wr6('h77, "R7"); seti('h40, "R7"); wr6('h80, "R7 init");
      rdi("R7 idx kept"); seti('h10, "R7"); rd6("R7 cleared"); seti('h40, "R7"); rd6("R7 cfg");
      // R9 control register
      seti('h49, "R9"); wr6('h13, "R9"); rd6("R9 rb");
      seti('h10, "R9"); wr6('h55, "R9"); seti('h49, "R9"); wr6('h20, "R9 rst");
      seti('h10, "R9"); rd6("R9 cleared");
      // random stream (R11 and all others together)
      for (int n = 0; n < 6000; n++) begin
         int k = $urandom % 10;
         if (k < 2)      op(5, 1, 0, pool[$urandom % 16] | (($urandom % 2) << 7), "R2 rnd");
         else if (k < 6) op(6, 0, 1, 0, "R11 rnd rd");
         else if (k < 9) op(6, 1, 0, $urandom % 256, "R11 rnd wr");
         else            op($urandom % 8, 0, 1, 0, "R2 rnd port");
      end
      @(negedge clk); bus_wr = 0; bus_rd = 0;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule